// File: doc/BRIEF.md
# Trace Word Unpacker

This block takes 32-bit words captured from a processor trace port and splits each word into per-cycle trace entries. The number of entries a word holds depends on the width of the trace port when the data was captured. A 4-bit port packs three entries per word, an 8-bit port packs two, and a 16-bit port packs one. Each entry has a 3-bit pipeline status, a packet field as wide as the port, a sync flag and a trigger flag.

The capture logic can mark a cycle as the trigger point by putting a reserved code in the status field. When the block sees that code, it replaces the status with the real status, which travels in the low three packet bits, and raises the trigger flag. Words come in on a valid/ready handshake and entries go out on another. Two static configuration inputs select the port width and the port link style. A combination that cannot be unpacked raises a configuration error and stops intake.

Top module: `trace_unpacker`

## Requirements
- R1: `width_sel` selects the port width: 2'b00 is 4-bit, 2'b01 is 8-bit and 2'b10 is 16-bit. The value 2'b11 is reserved and raises `cfg_bad`.
- R2: In 4-bit mode a word yields three entries from 8-bit slots at bit offsets 0, 8 and 16. Within a slot, bits [2:0] are the status, bits [6:3] the packet and bit 7 the sync flag.
- R3: In 8-bit mode a word yields two entries. The first entry takes its status from [2:0], its packet from [10:3] and its sync flag from bit 11. The second takes its status from [14:12], its packet from [22:15] and its sync flag from bit 23.
- R4: In 16-bit mode a word yields one entry: status [2:0], packet [18:3] and sync bit 19. A new word can be accepted in the same cycle that this entry is taken.
- R5: When a raw status equals the trigger code 3'b110, `out_status` carries the packet's low three bits and `out_trig` is 1. Otherwise `out_trig` is 0 and the raw status passes through unchanged.
- R6: Entries leave in ascending slot order. While `out_valid` is high and `out_ready` is low, every output field holds steady. A new word is accepted only in the cycle that the last entry of the current word is taken, or when the block is empty.
- R7: `link_sel` selects the link style: 2'b00 is normal, 2'b01 is demultiplexed and 2'b10 is multiplexed. `cfg_bad` is raised for the multiplexed style, for 2'b11, and for the demultiplexed style with any width other than 8-bit. While `cfg_bad` is high, `in_ready` is 0 and no word is accepted.
- R8: Input bits that the selected width does not use have no effect on any entry. These are bits [31:24] in 4-bit and 8-bit mode and bits [31:20] in 16-bit mode.
- R9: `out_packet` is zero-extended above the port width.
- R10: After reset, `out_valid` is 0. `in_ready` is 1 when the configuration is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 2 | Static port width select |
| link_sel | input | 2 | Static link style select |
| cfg_bad | output | 1 | Configuration cannot be unpacked |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Captured trace word |
| out_valid | output | 1 | Entry valid |
| out_ready | input | 1 | Consumer takes the entry |
| out_status | output | 3 | Resolved pipeline status |
| out_packet | output | 16 | Packet field, zero-extended |
| out_sync | output | 1 | Sync flag of the entry |
| out_trig | output | 1 | Entry was marked as the trigger cycle |

## Verification
The assertions check the handshake rules on every cycle:
- outputs hold steady during a stall;
- an accepted word produces an entry in the next cycle;
- `in_ready` stays low while the configuration is bad;
- a 16-bit entry releases intake in the cycle it is taken.

They also check two rules that involve only output fields:
- a triggered entry's status matches its packet's low bits;
- packet bits above the 4-bit port width stay zero.

The slot positions, the ascending order and the insensitivity to unused upper bits can only be shown by the bench, which compares each unpacked entry with values computed from chosen words.

// File: rtl/trace_unpacker.sv
module trace_unpacker #(
  parameter int         WORD_W    = 32,
  parameter int         PKT_W     = 16,
  parameter logic [2:0] TRIG_CODE = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        width_sel,
  input  logic [1:0]        link_sel,
  output logic              cfg_bad,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_status,
  output logic [PKT_W-1:0]  out_packet,
  output logic              out_sync,
  output logic              out_trig
);

  localparam int IDX_W = 2;

  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx;
  logic              busy;

  logic [WORD_W-1:0] slot;
  logic [2:0]        raw_stat;
  logic [PKT_W-1:0]  pkt;
  logic              sync;
  logic [IDX_W-1:0]  n_ent;
  logic              last;
  logic              accept;

  always_comb begin
    slot     = word_q;
    raw_stat = '0;
    pkt      = '0;
    sync     = 1'b0;
    n_ent    = 2'd1;
    case (width_sel)
      2'b00: begin
        slot     = word_q >> {idx, 3'b000};
        raw_stat = slot[2:0];
        pkt      = PKT_W'(slot[6:3]);
        sync     = slot[7];
        n_ent    = 2'd3;
      end
      2'b01: begin
        slot     = idx[0] ? (word_q >> 12) : word_q;
        raw_stat = slot[2:0];
        pkt      = PKT_W'(slot[10:3]);
        sync     = slot[11];
        n_ent    = 2'd2;
      end
      2'b10: begin
        raw_stat = slot[2:0];
        pkt      = PKT_W'(slot[18:3]);
        sync     = slot[19];
        n_ent    = 2'd1;
      end
      default: begin
        n_ent = 2'd1;
      end
    endcase
  end

  assign cfg_bad = (width_sel == 2'b11) || link_sel[1] ||
                   (link_sel == 2'b01 && width_sel != 2'b01);

  assign out_trig   = (raw_stat == TRIG_CODE);
  assign out_status = out_trig ? pkt[2:0] : raw_stat;
  assign out_packet = pkt;
  assign out_sync   = sync;
  assign out_valid  = busy;

  assign last     = (idx == n_ent - 2'd1);
  assign in_ready = !cfg_bad && (!busy || (out_ready && last));
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx    <= '0;
      busy   <= 1'b0;
    end else if (accept) begin
      word_q <= in_word;
      idx    <= '0;
      busy   <= 1'b1;
    end else if (busy && out_ready) begin
      if (last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 2'd1;
      end
    end
  end

endmodule

// File: rtl/trace_unpacker_chk.sv
module trace_unpacker_chk #(
  parameter int PKT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       width_sel,
  input logic             cfg_bad,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [2:0]       out_status,
  input logic [PKT_W-1:0] out_packet,
  input logic             out_sync,
  input logic             out_trig
);

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_status) &&
      $stable(out_packet) && $stable(out_sync) && $stable(out_trig));

  assert_accept_emits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_cfg_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> !in_ready);

  assert_trig_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trig |-> out_status == out_packet[2:0]);

  assert_narrow_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && width_sel == 2'b00 |-> out_packet[PKT_W-1:4] == '0);

  assert_wide_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && width_sel == 2'b10 && !cfg_bad |-> in_ready);

endmodule

bind trace_unpacker trace_unpacker_chk #(.PKT_W(PKT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .cfg_bad(cfg_bad),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_status(out_status), .out_packet(out_packet),
  .out_sync(out_sync), .out_trig(out_trig)
);

// File: tb/trace_unpacker_bench.sv
`timescale 1ns/1ps
module trace_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  width_sel = 2'b00;
  logic [1:0]  link_sel = 2'b00;
  logic        cfg_bad;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_status;
  logic [15:0] out_packet;
  logic        out_sync;
  logic        out_trig;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  trace_unpacker u_trace_unpacker (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .link_sel(link_sel),
    .cfg_bad(cfg_bad), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_status(out_status), .out_packet(out_packet), .out_sync(out_sync),
    .out_trig(out_trig)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // {trig, sync, packet[15:0], status[2:0]}
  function automatic logic [20:0] model(input logic [31:0] w,
                                        input logic [1:0] ws, input int k);
    logic [31:0] s;
    logic [2:0]  st;
    logic [15:0] pk;
    logic        sy;
    logic        tr;
    if (ws == 2'b00) begin
      s = w >> (8 * k); st = s[2:0]; pk = {12'h0, s[6:3]}; sy = s[7];
    end else if (ws == 2'b01) begin
      s = w >> (12 * k); st = s[2:0]; pk = {8'h0, s[10:3]}; sy = s[11];
    end else begin
      s = w; st = s[2:0]; pk = s[18:3]; sy = s[19];
    end
    tr = (st == 3'b110);
    if (tr) st = pk[2:0];
    return {tr, sy, pk, st};
  endfunction

  function automatic int count_of(input logic [1:0] ws);
    return (ws == 2'b00) ? 3 : (ws == 2'b01) ? 2 : 1;
  endfunction

  task automatic check_entry(input logic [31:0] w, input int k, input string req);
    logic [20:0] e;
    e = model(w, width_sel, k);
    chk(out_valid == 1'b1, req, 32'(out_valid), 32'd1);
    chk({out_trig, out_sync, out_packet, out_status} == e, req,
        32'({out_trig, out_sync, out_packet, out_status}), 32'(e));
  endtask

  task automatic run_word(input logic [31:0] w, input string req);
    @(negedge clk);
    in_word = w; in_valid = 1'b1;
    chk(in_ready == 1'b1, req, 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < count_of(width_sel); k++) begin
      check_entry(w, k, req);
      @(negedge clk);
    end
    chk(out_valid == 1'b0, req, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R10", 32'(out_valid), 32'd0);
    chk(in_ready == 1'b1, "R10", 32'(in_ready), 32'd1);
    chk(cfg_bad == 1'b0, "R10", 32'(cfg_bad), 32'd0);
  endtask

  task automatic t_four_bit;
    width_sel = 2'b00;
    run_word(32'hFF2ABE13, "R2 R5");
    run_word(32'h0019A7F0, "R2");
  endtask

  task automatic t_upper_ignored;
    logic [20:0] a [3];
    width_sel = 2'b00;
    for (int k = 0; k < 3; k++) a[k] = model(32'h00C4BE59, 2'b00, k);
    @(negedge clk);
    in_word = 32'h5AC4BE59; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk({out_trig, out_sync, out_packet, out_status} == a[k], "R8",
          32'({out_trig, out_sync, out_packet, out_status}), 32'(a[k]));
      @(negedge clk);
    end
    width_sel = 2'b10;
    run_word(32'hFFF12345, "R8 R4");
  endtask

  task automatic t_eight_bit;
    width_sel = 2'b01;
    run_word(32'hCC000000 | (32'h3B1 << 12) | 32'hA2E, "R3 R5");
    run_word(32'h00ABCDEF, "R3");
    link_sel = 2'b01;
    @(negedge clk);
    chk(cfg_bad == 1'b0, "R7", 32'(cfg_bad), 32'd0);
    run_word(32'h00765432, "R7 R3");
    link_sel = 2'b00;
  endtask

  task automatic t_sixteen_bit;
    width_sel = 2'b10;
    run_word((32'h1235 << 3) | 32'h6, "R4 R5 R9");
    run_word(32'h000FFFF1, "R4");
  endtask

  task automatic t_bad_cfg;
    width_sel = 2'b00; link_sel = 2'b01;
    @(negedge clk);
    chk(cfg_bad == 1'b1, "R7", 32'(cfg_bad), 32'd1);
    in_word = 32'h00112233; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b0, "R7", 32'(in_ready), 32'd0);
    chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
    link_sel = 2'b10; width_sel = 2'b01;
    @(negedge clk);
    chk(cfg_bad == 1'b1, "R7", 32'(cfg_bad), 32'd1);
    chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
    link_sel = 2'b00; width_sel = 2'b11;
    @(negedge clk);
    chk(cfg_bad == 1'b1, "R1", 32'(cfg_bad), 32'd1);
    chk(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
    in_valid = 1'b0; width_sel = 2'b00;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", 32'(out_valid), 32'd0);
  endtask

  task automatic t_stall;
    logic [31:0] wa;
    logic [31:0] wb;
    wa = 32'h00E7BE4A; wb = 32'h00330FD2;
    width_sel = 2'b00;
    @(negedge clk);
    out_ready = 1'b0; in_word = wa; in_valid = 1'b1;
    @(negedge clk);
    in_word = wb;
    for (int c = 0; c < 3; c++) begin
      check_entry(wa, 0, "R6");
      chk(in_ready == 1'b0, "R6", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check_entry(wa, k, "R6");
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check_entry(wb, k, "R6");
      @(negedge clk);
    end
    chk(out_valid == 1'b0, "R6", 32'(out_valid), 32'd0);
  endtask

  initial begin
    #(20ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=%h exp=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_four_bit();
    t_upper_ignored();
    t_eight_bit();
    t_sixteen_bit();
    t_bad_cfg();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule